// File: doc/BRIEF.md
# Interval / Watchdog Down-Counter

This block is a 32-bit down-counter owned by one processor. It runs in one of two modes. In interval mode it counts a programmed period. When the count expires it sets a status flag and can raise an interrupt. It can also restart itself from the stored period. In watchdog mode, expiry instead latches a reset-status flag and emits a one-cycle reset request, which system reset logic outside this block acts on. Software must refresh the period before the count reaches zero.

Once watchdog mode is entered, ordinary control writes cannot leave it. The only exit is an unlock pair written back to back into a dedicated write-only register: first 0x12345678, then 0x87654321. While watchdog mode is active, the counter register cannot be overwritten directly. A programmable prescaler divides the count rate by a power of sixteen.

Access is through a simple word-addressed register port with registered read data. Writes take effect at the clock edge on which `wr_en_i` is sampled.

Top module: `wdt_unit`

## Requirements
- R1: After reset, every readable register reads 0, and `irq_o` and `rst_req_o` are low.
- R2: Control sits at offset 0x08, with bit0 enable, bit1 auto-reload, bit2 interrupt enable, bit3 watchdog mode and bits[9:8] prescale. A control write can set bit3, but a control write with bit3 at 0 leaves it at 1. The other fields read back as written.
- R3: Watchdog mode is cleared only when the word written to the disable register (offset 0x14) is 0x87654321 and the previous write to that register was 0x12345678. Writes to other registers between the two words do not break the pair. Any other disable-register write in between does break it.
- R4: A write to the counter register (offset 0x04) is ignored in watchdog mode and stored in interval mode. The counter reads back at offset 0x04.
- R5: Writing the load register (offset 0x00) stores the value and restarts the count from it. A 0-to-1 change of the enable bit restarts the count from the stored load value. With load L and prescale 0, expiry takes effect at the L-th clock edge after the restarting write.
- R6: At expiry in interval mode, bit0 of interrupt status (offset 0x0C) is set. `irq_o` goes high only if interrupt enable is set. With auto-reload set, the next expiry follows L ticks later.
- R7: At expiry in watchdog mode, bit0 of reset status (offset 0x10) is set and `rst_req_o` pulses high for exactly one cycle. The counter stays at 0, interrupt status stays 0 and `irq_o` stays low.
- R8: Any write to offset 0x0C clears the interrupt flag and `irq_o`. Any write to offset 0x10 clears the reset flag.
- R9: A read of the disable register, an unmapped offset or a misaligned address returns 0 with `rd_err_o` high. Reads of the other registers have `rd_err_o` low.
- R10: With prescale field P, the counter steps once every 16^P clock cycles, so expiry comes 16^P x L edges after a restart.
- R11: Read data and `rd_err_o` are registered and valid in the cycle after `rd_en_i` is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | ADDR_W (5) | Byte address of the register |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Registered read data |
| rd_err_o | output | 1 | Registered read error flag |
| irq_o | output | 1 | Interval-mode interrupt, level |
| rst_req_o | output | 1 | One-cycle watchdog reset request |

## Verification
The expiry time is swept over loads 1 to 4 at each of the three lowest prescale settings. The bench samples `irq_o` one cycle before and at the computed edge, which separates an off-by-one count or a wrong divider from a correct one. Separate runs cover expiry with interrupt enable off, with auto-reload on, and after a mid-count reload, so flag setting, gating and restart are each told apart. The watchdog part drives the unlock words in order, reversed, broken by another disable-register word, and interleaved with other register writes. It also tries to clear the mode bit through control and to overwrite the counter in both modes.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  // register word indices (byte offset / 4)
  localparam int REG_LOAD  = 0;
  localparam int REG_CNT   = 1;
  localparam int REG_CTRL  = 2;
  localparam int REG_ISTAT = 3;
  localparam int REG_RSTAT = 4;
  localparam int REG_DIS   = 5;

  // control bit positions
  localparam int CB_EN     = 0;
  localparam int CB_RELOAD = 1;
  localparam int CB_IEN    = 2;
  localparam int CB_WD     = 3;
  localparam int CB_PSC    = 8;

  // unlock pair for leaving watchdog mode
  localparam logic [31:0] UNLOCK_FIRST  = 32'h1234_5678;
  localparam logic [31:0] UNLOCK_SECOND = 32'h8765_4321;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int PSC_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en_i,
  input  logic             restart_i,
  input  logic [PSC_W-1:0] psel_i,
  output logic             tick_o
);
  localparam int DIV_W = 4 * ((1 << PSC_W) - 1);

  logic [DIV_W-1:0] pre_q;
  logic [DIV_W-1:0] limit;

  // limit = 16^P - 1, i.e. the low 4*P bits set
  always_comb begin
    limit = '0;
    for (int i = 0; i < DIV_W; i++) begin
      if (i < 4 * int'(psel_i)) limit[i] = 1'b1;
    end
  end

  assign tick_o = en_i && (pre_q == limit);

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      pre_q <= '0;
    end else if (en_i) begin
      pre_q <= tick_o ? '0 : pre_q + 1'b1;
    end
  end
endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick_i,
  input  logic             restart_i,
  input  logic [CNT_W-1:0] restart_val_i,
  input  logic             reload_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             armed_q;

  assign cnt_o  = cnt_q;
  assign zero_o = tick_i && armed_q && !restart_i && (cnt_q <= CNT_W'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (restart_i) begin
      cnt_q   <= restart_val_i;
      armed_q <= 1'b1;
    end else if (tick_i && armed_q) begin
      if (cnt_q <= CNT_W'(1)) begin
        cnt_q   <= reload_i ? load_val_i : '0;
        armed_q <= reload_i;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/wdt_mode_guard.sv
module wdt_mode_guard #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ctrl_wr_i,
  input  logic              ctrl_wd_i,
  input  logic              dis_wr_i,
  input  logic [DATA_W-1:0] dis_val_i,
  output logic              wd_mode_o
);
  import wdt_pkg::*;

  logic [DATA_W-1:0] dis_q;
  logic              wd_q;

  assign wd_mode_o = wd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      dis_q <= '0;
      wd_q  <= 1'b0;
    end else begin
      if (dis_wr_i) dis_q <= dis_val_i;
      if (ctrl_wr_i && ctrl_wd_i) begin
        wd_q <= 1'b1;
      end else if (dis_wr_i && dis_q == DATA_W'(UNLOCK_FIRST) &&
                   dis_val_i == DATA_W'(UNLOCK_SECOND)) begin
        wd_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wdt_unit.sv
module wdt_unit #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int PSC_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              rd_err_o,
  output logic              irq_o,
  output logic              rst_req_o
);
  import wdt_pkg::*;

  localparam int SEL_W = ADDR_W - 2;

  logic [SEL_W-1:0]  sel;
  logic              aligned;
  logic              wr_load, wr_cnt, wr_ctrl, wr_istat, wr_rstat, wr_dis;
  logic [DATA_W-1:0] load_q;
  logic              en_q, arl_q, ien_q;
  logic [PSC_W-1:0]  psc_q;
  logic              wd_mode;
  logic              raw_q, pend_q, rsts_q, rst_req_q;
  logic              restart;
  logic [DATA_W-1:0] restart_val;
  logic              tick, zero;
  logic [DATA_W-1:0] cnt;
  logic [DATA_W-1:0] ctrl_word;
  logic [DATA_W-1:0] rdata_q;
  logic              rderr_q;

  assign sel     = addr_i[ADDR_W-1:2];
  assign aligned = (addr_i[1:0] == 2'b00);

  assign wr_load  = wr_en_i && aligned && sel == SEL_W'(REG_LOAD);
  assign wr_cnt   = wr_en_i && aligned && sel == SEL_W'(REG_CNT);
  assign wr_ctrl  = wr_en_i && aligned && sel == SEL_W'(REG_CTRL);
  assign wr_istat = wr_en_i && aligned && sel == SEL_W'(REG_ISTAT);
  assign wr_rstat = wr_en_i && aligned && sel == SEL_W'(REG_RSTAT);
  assign wr_dis   = wr_en_i && aligned && sel == SEL_W'(REG_DIS);

  // restart sources, one bus access per cycle so at most one fires
  always_comb begin
    restart     = 1'b0;
    restart_val = load_q;
    if (wr_load) begin
      restart     = 1'b1;
      restart_val = wdata_i;
    end else if (wr_cnt && !wd_mode) begin
      restart     = 1'b1;
      restart_val = wdata_i;
    end else if (wr_ctrl && !en_q && wdata_i[CB_EN]) begin
      restart     = 1'b1;
      restart_val = load_q;
    end
  end

  wdt_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk       (clk),
    .rst       (rst),
    .en_i      (en_q),
    .restart_i (restart),
    .psel_i    (psc_q),
    .tick_o    (tick)
  );

  wdt_downcount #(.CNT_W(DATA_W)) u_cnt (
    .clk           (clk),
    .rst           (rst),
    .tick_i        (tick),
    .restart_i     (restart),
    .restart_val_i (restart_val),
    .reload_i      (arl_q && !wd_mode),
    .load_val_i    (load_q),
    .cnt_o         (cnt),
    .zero_o        (zero)
  );

  wdt_mode_guard #(.DATA_W(DATA_W)) u_guard (
    .clk       (clk),
    .rst       (rst),
    .ctrl_wr_i (wr_ctrl),
    .ctrl_wd_i (wdata_i[CB_WD]),
    .dis_wr_i  (wr_dis),
    .dis_val_i (wdata_i),
    .wd_mode_o (wd_mode)
  );

  // register file
  always_ff @(posedge clk) begin
    if (rst) begin
      load_q <= '0;
      en_q   <= 1'b0;
      arl_q  <= 1'b0;
      ien_q  <= 1'b0;
      psc_q  <= '0;
    end else begin
      if (wr_load) load_q <= wdata_i;
      if (wr_ctrl) begin
        en_q  <= wdata_i[CB_EN];
        arl_q <= wdata_i[CB_RELOAD];
        ien_q <= wdata_i[CB_IEN];
        psc_q <= wdata_i[CB_PSC +: PSC_W];
      end
    end
  end

  // expiry flags: a setting event wins over a clearing write
  always_ff @(posedge clk) begin
    if (rst) begin
      raw_q     <= 1'b0;
      pend_q    <= 1'b0;
      rsts_q    <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      if (zero && !wd_mode)       raw_q <= 1'b1;
      else if (wr_istat)          raw_q <= 1'b0;
      if (zero && !wd_mode && ien_q) pend_q <= 1'b1;
      else if (wr_istat)          pend_q <= 1'b0;
      if (zero && wd_mode)        rsts_q <= 1'b1;
      else if (wr_rstat)          rsts_q <= 1'b0;
      rst_req_q <= zero && wd_mode;
    end
  end

  always_comb begin
    ctrl_word                   = '0;
    ctrl_word[CB_EN]            = en_q;
    ctrl_word[CB_RELOAD]        = arl_q;
    ctrl_word[CB_IEN]           = ien_q;
    ctrl_word[CB_WD]            = wd_mode;
    ctrl_word[CB_PSC +: PSC_W]  = psc_q;
  end

  // registered read port
  always_ff @(posedge clk) begin
    if (rst || !rd_en_i) begin
      rdata_q <= '0;
      rderr_q <= 1'b0;
    end else begin
      rdata_q <= '0;
      rderr_q <= 1'b0;
      if (!aligned) begin
        rderr_q <= 1'b1;
      end else begin
        case (int'(sel))
          REG_LOAD:  rdata_q <= load_q;
          REG_CNT:   rdata_q <= cnt;
          REG_CTRL:  rdata_q <= ctrl_word;
          REG_ISTAT: rdata_q <= DATA_W'(raw_q);
          REG_RSTAT: rdata_q <= DATA_W'(rsts_q);
          default:   rderr_q <= 1'b1;
        endcase
      end
    end
  end

  assign rdata_o   = rdata_q;
  assign rd_err_o  = rderr_q;
  assign irq_o     = pend_q;
  assign rst_req_o = rst_req_q;
endmodule

// File: rtl/wdt_unit_chk.sv
module wdt_unit_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] rdata_o,
  input logic              rd_err_o,
  input logic              irq_o,
  input logic              rst_req_o,
  input logic              wd_mode,
  input logic              en,
  input logic [DATA_W-1:0] cnt,
  input logic              rst_flag
);
  import wdt_pkg::*;

  logic to_dis, to_cnt;
  assign to_dis = wr_en_i && addr_i == ADDR_W'(REG_DIS * 4);
  assign to_cnt = wr_en_i && addr_i == ADDR_W'(REG_CNT * 4);

  AST_WD_STICKY: assert property (@(posedge clk) disable iff (rst)
    (wd_mode && !to_dis) |=> wd_mode); // R2

  AST_WD_EXIT_BY_UNLOCK: assert property (@(posedge clk) disable iff (rst)
    $fell(wd_mode) |-> $past(to_dis && wdata_i == DATA_W'(UNLOCK_SECOND))); // R3

  AST_CNT_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (wd_mode && !en && to_cnt) |=> $stable(cnt)); // R4

  AST_RST_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |=> !rst_req_o); // R7

  AST_RST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> rst_flag); // R7

  AST_NO_IRQ_WD: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_o) |-> $past(!wd_mode)); // R7

  AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
    rd_err_o |-> (rdata_o == '0)); // R9
endmodule

bind wdt_unit wdt_unit_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .wr_en_i   (wr_en_i),
  .addr_i    (addr_i),
  .wdata_i   (wdata_i),
  .rdata_o   (rdata_o),
  .rd_err_o  (rd_err_o),
  .irq_o     (irq_o),
  .rst_req_o (rst_req_o),
  .wd_mode   (wd_mode),
  .en        (en_q),
  .cnt       (cnt),
  .rst_flag  (rsts_q)
);

// File: tb/tb_wdt_unit.sv
module tb_wdt_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic [4:0]  addr_i = '0;
  logic [31:0] wdata_i = '0;
  logic [31:0] rdata_o;
  logic        rd_err_o, irq_o, rst_req_o;

  int total = 0;
  int bad   = 0;

  localparam logic [4:0] A_LOAD = 5'h00, A_CNT = 5'h04, A_CTRL = 5'h08,
                         A_IST = 5'h0C, A_RST = 5'h10, A_DIS = 5'h14;

  always #10 clk = ~clk;

  wdt_unit dut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .rd_err_o(rd_err_o), .irq_o(irq_o), .rst_req_o(rst_req_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d, output logic e);
    rd_en_i = 1'b1; addr_i = a;
    @(negedge clk);
    rd_en_i = 1'b0;
    d = rdata_o; e = rd_err_o;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    logic        e;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 irq", {31'd0, irq_o}, 0);
    chk("R1 rst_req", {31'd0, rst_req_o}, 0);
    rd(A_LOAD, v, e); chk("R1 load", v, 0);
    rd(A_CNT, v, e);  chk("R1 cnt", v, 0);
    rd(A_CTRL, v, e); chk("R1 ctrl", v, 0);
    rd(A_IST, v, e);  chk("R1 istat", v, 0);
    rd(A_RST, v, e);  chk("R1 rstat", v, 0); chk("R11 err low", {31'd0, e}, 0);

    // R10 / R5 / R6 sweep: expiry at 16^P * L edges after enabling
    for (int p = 0; p < 3; p++) begin
      for (int l = 1; l <= 4; l++) begin
        int n;
        n = (1 << (4 * p)) * l;
        wr(A_CTRL, 0);
        wr(A_IST, 0);
        wr(A_LOAD, l);
        wr(A_CTRL, 32'h5 | (p << 8));
        wait_n(n - 1);
        chk($sformatf("R10 early p=%0d l=%0d", p, l), {31'd0, irq_o}, 0);
        wait_n(1);
        chk($sformatf("R5 expiry p=%0d l=%0d", p, l), {31'd0, irq_o}, 1);
      end
    end
    rd(A_CTRL, v, e); chk("R2 ctrl readback", v, 32'h205);

    // R8 clear interrupt
    wr(A_IST, 32'hFFFF);
    chk("R8 irq cleared", {31'd0, irq_o}, 0);
    rd(A_IST, v, e); chk("R8 istat cleared", v, 0);

    // R6 interrupt enable off: flag set, no irq
    wr(A_CTRL, 0);
    wr(A_LOAD, 3);
    wr(A_CTRL, 32'h1);
    wait_n(5);
    chk("R6 no irq when disabled", {31'd0, irq_o}, 0);
    rd(A_IST, v, e); chk("R6 raw flag", v, 1);

    // R6 auto-reload period
    wr(A_CTRL, 0);
    wr(A_IST, 0);
    wr(A_LOAD, 4);
    wr(A_CTRL, 32'h7);
    wait_n(3); chk("R6 reload first early", {31'd0, irq_o}, 0);
    wait_n(1); chk("R6 reload first", {31'd0, irq_o}, 1);
    wr(A_IST, 0);
    wait_n(2); chk("R6 reload second early", {31'd0, irq_o}, 0);
    wait_n(1); chk("R6 reload second", {31'd0, irq_o}, 1);

    // R5 load write mid-count restarts
    wr(A_CTRL, 0);
    wr(A_IST, 0);
    wr(A_LOAD, 10);
    wr(A_CTRL, 32'h5);
    wait_n(3);
    wr(A_LOAD, 4);
    wait_n(3); chk("R5 restart early", {31'd0, irq_o}, 0);
    wait_n(1); chk("R5 restart expiry", {31'd0, irq_o}, 1);

    // R7 watchdog expiry
    wr(A_CTRL, 0);
    wr(A_IST, 0);
    wr(A_LOAD, 3);
    wr(A_CTRL, 32'hD);
    wait_n(2); chk("R7 rst_req early", {31'd0, rst_req_o}, 0);
    wait_n(1); chk("R7 rst_req pulse", {31'd0, rst_req_o}, 1);
    chk("R7 no irq", {31'd0, irq_o}, 0);
    wait_n(1); chk("R7 rst_req one cycle", {31'd0, rst_req_o}, 0);
    wait_n(20); chk("R7 no reload", {31'd0, rst_req_o}, 0);
    rd(A_RST, v, e); chk("R7 reset flag", v, 1);
    rd(A_IST, v, e); chk("R7 istat zero", v, 0);
    rd(A_CNT, v, e); chk("R7 counter held at 0", v, 0);
    rd(A_CTRL, v, e); chk("R2 wd bit set", v, 32'hD);
    wr(A_RST, 0);
    rd(A_RST, v, e); chk("R8 reset flag cleared", v, 0);

    // R2 sticky against control writes
    wr(A_CTRL, 0);
    rd(A_CTRL, v, e); chk("R2 wd sticky", v, 32'h8);

    // R4 counter protected in watchdog mode
    wr(A_LOAD, 7);
    rd(A_CNT, v, e); chk("R5 load sets counter", v, 7);
    wr(A_CNT, 32'h55);
    rd(A_CNT, v, e); chk("R4 counter write ignored", v, 7);

    // R3 wrong orders keep watchdog mode
    wr(A_DIS, 32'h8765_4321);
    wr(A_DIS, 32'h1234_5678);
    rd(A_CTRL, v, e); chk("R3 reversed pair", v, 32'h8);
    wr(A_DIS, 32'hABCD);
    wr(A_DIS, 32'h8765_4321);
    rd(A_CTRL, v, e); chk("R3 broken pair", v, 32'h8);
    wr(A_DIS, 32'h1234_5678);
    wr(A_DIS, 32'h0);
    wr(A_DIS, 32'h8765_4321);
    rd(A_CTRL, v, e); chk("R3 intervening dis write", v, 32'h8);
    // R3 valid pair with another register written between
    wr(A_DIS, 32'h1234_5678);
    wr(A_LOAD, 2);
    wr(A_DIS, 32'h8765_4321);
    rd(A_CTRL, v, e); chk("R3 unlock", v, 0);

    // R4 counter writable in interval mode
    wr(A_CNT, 32'h55);
    rd(A_CNT, v, e); chk("R4 counter write taken", v, 32'h55);

    // R9 / R11 error reads
    rd(A_DIS, v, e); chk("R9 dis data", v, 0); chk("R9 dis err", {31'd0, e}, 1);
    rd(5'h1C, v, e); chk("R9 unmapped err", {31'd0, e}, 1);
    rd(5'h01, v, e); chk("R9 misaligned err", {31'd0, e}, 1);
    rd(A_LOAD, v, e); chk("R11 load data", v, 2); chk("R9 load err", {31'd0, e}, 0);
    wait_n(1);
    chk("R11 err pulse ends", {31'd0, rd_err_o}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule